// File: doc/BRIEF.md
# Wormhole Allocation Hold Monitor

This block watches a five-port wormhole router from the outside and checks one rule on every port. When a port is sending and the output it is mapped to is marked busy, that allocation is taken to belong to the flow. From then on the output must stay busy, and the mapping must keep naming the same input, for as long as the port keeps sending. The obligation ends without error when the port's sending bit drops, because that marks the end of the packet.

For each port the monitor receives three things: a sending bit, a 3-bit source index that names an output, and the output's free bit. The free bits for all outputs come in as one vector. The monitor gives a one-cycle violation pulse for each port and a sticky fail flag that merges all ports. A source index that names no existing port is reported as a violation in every cycle in which that port is sending. The monitor is synthesizable, so it can sit next to the router in silicon as an on-line safety check, or run alongside it in simulation.

Top module: `wh_hold_monitor`

## Requirements
- R1: While rst_n is low, port_viol is all zero and any_fail is 0.
- R2: A port's obligation opens at a clock edge where its sending bit is 1, its source index (bits [3i+2:3i] of src_sel for port i) is in 0..4, and out_free at that index is 0. A held obligation raises no pulse.
- R3: If an obligation is open and, at the next edge, the port is still sending with the same source index but out_free at that index is 1, then port_viol[i] is 1 for the one cycle after that edge.
- R4: If an obligation is open and the port is still sending but its source index differs from the one latched when the obligation opened, port_viol[i] pulses in the cycle after that edge.
- R5: When the sending bit is 0 at an edge, no pulse follows for that port and any open obligation is released. This holds even if the free bit or the index changes in the same cycle.
- R6: At any edge where a port is sending with a source index of 5, 6 or 7, port_viol[i] is 1 in the following cycle, whether or not an obligation was open.
- R7: A port that is sending with a valid index and has no open obligation raises no pulse, even if its output is free.
- R8: Ports are checked independently. A violation on one port does not pulse any other port's bit.
- R9: any_fail rises in the cycle after any port_viol bit is 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| out_free | input | 5 | Free bit of each router output, 1 = unallocated |
| src_sel | input | 15 | Per-port 3-bit source index, port i in bits [3i+2:3i] |
| sending | input | 5 | Per-port sender-active bit |
| port_viol | output | 5 | Per-port violation pulse, registered |
| any_fail | output | 1 | Sticky OR of all port violations |

## Verification
Port 0 is swept over every pair of opening index and follow-up index (valid and out of range), all 32 free patterns, and both values of the follow-up sending bit. This separates a clean hold from a free-bit break (R3), an index swap (R4), a release (R5), a bad index (R6) and a pulse-free first cycle (R7). A pseudo-random phase then drives all five ports at once, mostly holding allocations with occasional breaks, so that crosstalk between ports would show (R8). Directed cases cover a long clean hold, a mid-run reset, and the sticky fail flag.

// File: rtl/wh_mon_pkg.sv
package wh_mon_pkg;
  localparam int unsigned WH_PORTS = 5;
  localparam int unsigned WH_IDX_W = 3;
endpackage

// File: rtl/wh_port_track.sv
module wh_port_track #(
  parameter int unsigned NUM_PORTS = wh_mon_pkg::WH_PORTS,
  parameter int unsigned IDX_W     = wh_mon_pkg::WH_IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] out_free,
  input  logic [IDX_W-1:0]     src_idx,
  input  logic                 sending,
  output logic                 viol_q
);
  localparam int unsigned EXT_W = 1 << IDX_W;

  logic [EXT_W-1:0] free_ext;
  logic             idx_ok;
  logic             free_at_idx;
  logic             hold_d;
  logic             viol_d;
  logic             open_q;
  logic             open_d;
  logic [IDX_W-1:0] src_q;
  logic             src_en;

  // Outputs past the last port read as free, so they never open an obligation.
  always_comb begin
    free_ext                = '1;
    free_ext[NUM_PORTS-1:0] = out_free;
    idx_ok                  = (int'(src_idx) < NUM_PORTS);
    free_at_idx             = free_ext[src_idx];
    hold_d                  = sending & idx_ok & ~free_at_idx;
    viol_d                  = sending & (~idx_ok |
                              (open_q & ((src_idx != src_q) | free_at_idx)));
    open_d                  = hold_d;
    src_en                  = hold_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      open_q <= open_d;
      viol_q <= viol_d;
    end
  end

  // Data register, only meaningful while open_q is set.
  always_ff @(posedge clk) begin
    if (src_en) begin
      src_q <= src_idx;
    end
  end
endmodule

// File: rtl/wh_fail_latch.sv
module wh_fail_latch #(
  parameter int unsigned NUM_PORTS = wh_mon_pkg::WH_PORTS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] viol,
  output logic                 fail_q
);
  logic fail_d;

  always_comb begin
    fail_d = fail_q | (|viol);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
    end else begin
      fail_q <= fail_d;
    end
  end
endmodule

// File: rtl/wh_hold_monitor.sv
module wh_hold_monitor #(
  parameter int unsigned NUM_PORTS = wh_mon_pkg::WH_PORTS,
  parameter int unsigned IDX_W     = wh_mon_pkg::WH_IDX_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PORTS-1:0]       out_free,
  input  logic [NUM_PORTS*IDX_W-1:0] src_sel,
  input  logic [NUM_PORTS-1:0]       sending,
  output logic [NUM_PORTS-1:0]       port_viol,
  output logic                       any_fail
);
  genvar gp;
  generate
    for (gp = 0; gp < NUM_PORTS; gp++) begin : g_port
      wh_port_track #(
        .NUM_PORTS (NUM_PORTS),
        .IDX_W     (IDX_W)
      ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .out_free (out_free),
        .src_idx  (src_sel[gp*IDX_W +: IDX_W]),
        .sending  (sending[gp]),
        .viol_q   (port_viol[gp])
      );
    end
  endgenerate

  wh_fail_latch #(
    .NUM_PORTS (NUM_PORTS)
  ) u_fail (
    .clk    (clk),
    .rst_n  (rst_n),
    .viol   (port_viol),
    .fail_q (any_fail)
  );
endmodule

// File: rtl/wh_hold_monitor_chk.sv
module wh_hold_monitor_chk #(
  parameter int unsigned NUM_PORTS = wh_mon_pkg::WH_PORTS,
  parameter int unsigned IDX_W     = wh_mon_pkg::WH_IDX_W
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_PORTS-1:0]       out_free,
  input logic [NUM_PORTS*IDX_W-1:0] src_sel,
  input logic [NUM_PORTS-1:0]       sending,
  input logic [NUM_PORTS-1:0]       port_viol,
  input logic                       any_fail
);
  localparam int unsigned EXT_W = 1 << IDX_W;

  logic [EXT_W-1:0] free_ext;
  always_comb begin
    free_ext                = '1;
    free_ext[NUM_PORTS-1:0] = out_free;
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (port_viol == '0 && any_fail == 1'b0)
        else $error("outputs not cleared during reset");
    end
  end

  // R9
  assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    any_fail |=> any_fail);
  assert_fail_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|port_viol) |=> any_fail);

  genvar gc;
  generate
    for (gc = 0; gc < NUM_PORTS; gc++) begin : g_chk
      logic [IDX_W-1:0] idx;
      logic             ok;
      logic             held_q;
      logic [IDX_W-1:0] held_src_q;

      always_comb begin
        idx = src_sel[gc*IDX_W +: IDX_W];
        ok  = (int'(idx) < NUM_PORTS);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          held_q     <= 1'b0;
          held_src_q <= '0;
        end else begin
          held_q     <= sending[gc] & ok & ~free_ext[idx];
          held_src_q <= idx;
        end
      end

      assert_bad_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sending[gc] && !ok) |=> port_viol[gc]);
      assert_release_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sending[gc] |=> !port_viol[gc]);
      assert_free_break_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && sending[gc] && idx == held_src_q && free_ext[idx]) |=> port_viol[gc]);
      assert_source_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && sending[gc] && idx != held_src_q) |=> port_viol[gc]);
      assert_first_cycle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!held_q && sending[gc] && ok) |=> !port_viol[gc]);
      assert_clean_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && sending[gc] && idx == held_src_q && !free_ext[idx]) |=> !port_viol[gc]);
    end
  endgenerate
endmodule

bind wh_hold_monitor wh_hold_monitor_chk #(
  .NUM_PORTS (NUM_PORTS),
  .IDX_W     (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_free  (out_free),
  .src_sel   (src_sel),
  .sending   (sending),
  .port_viol (port_viol),
  .any_fail  (any_fail)
);

// File: tb/wh_hold_monitor_test.sv
`timescale 1ns/1ps
module wh_hold_monitor_test;
  logic        clk;
  logic        rst_n;
  logic [4:0]  out_free;
  logic [14:0] src_sel;
  logic [4:0]  sending;
  logic [4:0]  port_viol;
  logic        any_fail;

  int checks;
  int failures;
  bit done;

  logic       m_open [5];
  logic [2:0] m_src  [5];
  logic [4:0] m_viol;
  logic       m_fail;
  logic [31:0] rng;

  wh_hold_monitor uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_free  (out_free),
    .src_sel   (src_sel),
    .sending   (sending),
    .port_viol (port_viol),
    .any_fail  (any_fail)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #750000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < 5; p++) begin
      m_open[p] = 1'b0;
      m_src[p]  = 3'd0;
    end
    m_viol = 5'd0;
    m_fail = 1'b0;
  endtask

  // Drive one cycle of inputs, then compare after the edge that samples them.
  task automatic step(input logic [4:0] fr, input logic [14:0] sr, input logic [4:0] sn);
    logic [4:0] exp_v;
    logic       exp_f;
    logic       nopen [5];
    string      tag   [5];
    out_free = fr;
    src_sel  = sr;
    sending  = sn;
    for (int p = 0; p < 5; p++) begin
      logic [2:0] ix;
      logic       bad;
      logic       fi;
      ix  = sr[3*p +: 3];
      bad = (ix > 3'd4);
      fi  = bad ? 1'b1 : fr[ix];
      exp_v[p] = sn[p] && (bad || (m_open[p] && (ix != m_src[p] || fi)));
      nopen[p] = sn[p] && !bad && !fi;
      if (!sn[p])                tag[p] = "R5";
      else if (bad)              tag[p] = "R6";
      else if (!m_open[p])       tag[p] = "R7";
      else if (ix != m_src[p])   tag[p] = "R4";
      else if (fi)               tag[p] = "R3";
      else                       tag[p] = "R2";
      if (nopen[p]) m_src[p] = ix;
      m_open[p] = nopen[p];
    end
    exp_f = m_fail | (|m_viol);
    @(posedge clk);
    #1;
    for (int p = 0; p < 5; p++) begin
      check($sformatf("%s port %0d port_viol", tag[p], p), 32'(port_viol[p]), 32'(exp_v[p]));
    end
    check("R9 any_fail", 32'(any_fail), 32'(exp_f));
    m_viol = exp_v;
    m_fail = exp_f;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    out_free = 5'h1f;
    src_sel  = 15'd0;
    sending  = 5'd0;
    @(posedge clk);
    #1;
    check("R1 port_viol in reset", 32'(port_viol), 32'd0);
    check("R1 any_fail in reset", 32'(any_fail), 32'd0);
    rst_n = 1'b1;
    model_reset();
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    checks   = 0;
    failures = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    out_free = 5'h1f;
    src_sel  = 15'd0;
    sending  = 5'd0;
    model_reset();
    #1;
    do_reset();

    // R2: clean hold on port 1 from output 3, then break it (R3).
    step(5'h17, 15'(3 << 3), 5'b00010);
    for (int k = 0; k < 4; k++) step(5'h17, 15'(3 << 3), 5'b00010);
    check("R2 clean hold gives no pulse", 32'(port_viol), 32'd0);
    step(5'h1f, 15'(3 << 3), 5'b00010);
    check("R3 free rise on held output", 32'(port_viol), 32'b00010);
    step(5'h1f, 15'd0, 5'd0);
    check("R9 fail stays set", 32'(any_fail), 32'd1);

    // R8: bad index on port 2 while ports 0 and 4 hold cleanly.
    do_reset();
    step(5'h1c, {3'd1, 3'd0, 3'd6, 3'd0, 3'd0}, 5'b10001);
    step(5'h1c, {3'd1, 3'd0, 3'd6, 3'd0, 3'd0}, 5'b10101);
    check("R8 only port 2 pulses", 32'(port_viol), 32'b00100);
    step(5'h1c, {3'd1, 3'd0, 3'd0, 3'd0, 3'd0}, 5'b10001);
    check("R8 others stay quiet", 32'(port_viol & 5'b11011), 32'd0);

    // Exhaustive port-0 sweep: open on a, then test b / free / sending.
    do_reset();
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        for (int f = 0; f < 32; f++) begin
          for (int s = 0; s < 2; s++) begin
            logic [4:0] f1;
            f1 = (a < 5) ? (5'h1f & ~(5'd1 << a)) : 5'd0;
            step(f1, 15'(a), 5'b00001);
            step(5'(f), 15'(b), 5'(s));
            step(5'h1f, 15'd0, 5'd0);
          end
        end
      end
    end

    // Pseudo-random all-port phase.
    do_reset();
    rng = 32'h1badc0de;
    begin
      logic [4:0]  sn;
      logic [14:0] sr;
      sn = 5'd0;
      sr = 15'd0;
      for (int k = 0; k < 5000; k++) begin
        logic [4:0] fr;
        for (int p = 0; p < 5; p++) begin
          rng = next_rng(rng);
          if (rng[2:0] == 3'd0) sn[p] = ~sn[p];
          if (rng[4:3] == 2'd0) sr[3*p +: 3] = (rng[7:5] == 3'd7) ? rng[10:8] : 3'(rng[10:8] % 5);
        end
        rng = next_rng(rng);
        fr  = rng[4:0] & rng[9:5] & rng[14:10];
        step(fr, sr, sn);
        if (k == 2500) do_reset();
      end
    end

    done = 1'b1;
    summary();
  end
endmodule